// File: doc/BRIEF.md
# Half-Precision Fused Multiply-Add Unit

This unit takes three IEEE 754 binary16 operands and returns plus or minus (a × b) + c as one binary16 value, together with five exception flags. The product of a and b is never rounded. It is kept exactly, optionally negated, aligned with the addend in a wide fixed-point accumulator, and the sum is rounded once to binary16 under a 2-bit rounding-mode input. Subnormal operands and results, infinities, NaNs and signed zeros are all handled. There is no flush-to-zero mode.

The arithmetic is combinational and feeds one output register. A request presented with `in_valid` high produces its result on the next clock with `out_valid` high. The surrounding datapath is responsible for choosing which registers feed `op_a`, `op_b` and `op_c`.

Top module: `hfma16`

## Requirements
- R1: `out_valid` is high in exactly the cycle after one in which `in_valid` is high, and `result`/`flags` then hold the outcome for the operands sampled with that `in_valid`; with `in_valid` low, `out_valid` is low one cycle later.
- R2: While `rst_n` is low, `out_valid`, `result` and `flags` are all zero.
- R3: For finite operands the result equals the exact real value a × b + c rounded once to binary16; the product is never rounded on its own (for example 0x3C01 × 0x3C01 + 0xBC02 gives 0x0010, not zero).
- R4: With `negate` high the exact product is negated before the addend is added, giving -(a × b) + c with a single rounding.
- R5: `rmode` 00 rounds to nearest with ties to even, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero.
- R6: Subnormal operands and subnormal results are computed exactly as IEEE values; the denormal flag `flags[1]` is set whenever any of the three operands is subnormal (exponent field 0, fraction nonzero).
- R7: Any NaN operand gives the quiet NaN 0x7E00. The invalid flag `flags[0]` is set, with result 0x7E00, for a signalling NaN operand (exponent all ones, fraction nonzero, fraction bit 9 clear), for infinity × zero, and for an infinite product added to an infinite addend of opposite sign.
- R8: An exactly zero sum of terms of opposite sign is +0 in every mode except 01, where it is -0; a zero sum of two terms of the same sign keeps that sign.
- R9: When the rounded magnitude exceeds 0x7BFF, `flags[2]` (overflow) and `flags[4]` (inexact) are set and the result is infinity under mode 00, the largest finite value 0x7BFF under mode 11, and under modes 01/10 infinity only when the rounding direction points away from zero for that sign.
- R10: `flags[4]` (inexact) is set when the rounded result differs from the exact value; `flags[3]` (underflow) is set when the exact nonzero value has magnitude below 2^-14 and the result is inexact.
- R11: With no NaN and no invalid case, an infinite product or infinite addend gives infinity carrying that term's sign, with no flag other than the denormal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 16 | First factor, binary16 |
| op_b | input | 16 | Second factor, binary16 |
| op_c | input | 16 | Addend, binary16 |
| negate | input | 1 | Negate the exact product before the addition |
| rmode | input | 2 | Rounding mode: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| out_valid | output | 1 | Result and flags valid |
| result | output | 16 | Rounded binary16 result |
| flags | output | 5 | {inexact, underflow, overflow, denormal, invalid} |

## Verification
The bench targets the cases where a fused unit departs from a multiply followed by an add. These are near-total cancellation, where a unit that rounds the product first would return zero, and exact ties, where a wrong tie rule would round to the odd neighbour. It also covers the subnormal range, where a misplaced rounding position shifts results by a power of two or drops the underflow flag. At the edges, wrong choices show up as a -0 in the wrong mode, infinity instead of 0x7BFF on overflow toward zero, or a missing invalid flag on infinity × zero. Random operands weighted toward subnormals, specials and near-equal exponents are checked against a wide-integer model, with addends built to cancel the product.

// File: rtl/hfma16.sv
module hfma16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic [15:0] op_c,
  input  logic        negate,
  input  logic [1:0]  rmode,
  output logic        out_valid,
  output logic [15:0] result,
  output logic [4:0]  flags
);
  localparam int EW = 5;
  localparam int FW = 10;
  localparam int SW = FW + 1;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int ACC_W = 2 * ((1 << EW) - 2) - 2 + 2 * SW + 2;
  localparam int C_BASE = BIAS + FW - 2;
  localparam int SUB_LSB = BIAS - 1 + FW;
  localparam int NORM_LEAD = SUB_LSB + FW;

  // {snan, nan, inf, sub}
  function automatic logic [3:0] classify(input logic [15:0] x);
    logic emax, ezero, fzero;
    emax  = &x[14:10];
    ezero = ~|x[14:10];
    fzero = ~|x[9:0];
    return {emax & ~fzero & ~x[9], emax & ~fzero, emax & fzero, ezero & ~fzero};
  endfunction

  logic [3:0] ka, kb, kc;
  logic a_zero, b_zero;
  assign ka = classify(op_a);
  assign kb = classify(op_b);
  assign kc = classify(op_c);
  assign a_zero = ~|op_a[14:0];
  assign b_zero = ~|op_b[14:0];

  logic [EW-1:0] eff_a, eff_b, eff_c;
  logic [SW-1:0] sig_a, sig_b, sig_c;
  assign eff_a = op_a[14:10] | {{(EW-1){1'b0}}, ~|op_a[14:10]};
  assign eff_b = op_b[14:10] | {{(EW-1){1'b0}}, ~|op_b[14:10]};
  assign eff_c = op_c[14:10] | {{(EW-1){1'b0}}, ~|op_c[14:10]};
  assign sig_a = {|op_a[14:10], op_a[9:0]};
  assign sig_b = {|op_b[14:10], op_b[9:0]};
  assign sig_c = {|op_c[14:10], op_c[9:0]};

  logic ps, cs;
  logic [2*SW-1:0] prod;
  logic [EW:0] pshift, cshift;
  logic [ACC_W-1:0] pfx, cfx, mag;
  logic rsign;
  assign ps = op_a[15] ^ op_b[15] ^ negate;
  assign cs = op_c[15];
  assign prod = sig_a * sig_b;
  assign pshift = {1'b0, eff_a} + {1'b0, eff_b} - (EW+1)'(2);
  assign cshift = {1'b0, eff_c} + (EW+1)'(C_BASE);
  assign pfx = ACC_W'(prod) << pshift;
  assign cfx = ACC_W'(sig_c) << cshift;

  always_comb begin
    if (ps == cs) begin
      mag = pfx + cfx;
      rsign = ps;
    end else if (pfx >= cfx) begin
      mag = pfx - cfx;
      rsign = ps;
    end else begin
      mag = cfx - pfx;
      rsign = cs;
    end
  end

  logic [6:0] lead, lsb;
  always_comb begin
    lead = '0;
    for (int i = 0; i < ACC_W; i++)
      if (mag[i]) lead = 7'(i);
  end
  assign lsb = (lead >= 7'(NORM_LEAD)) ? lead - 7'(FW) : 7'(SUB_LSB);

  logic [SW:0] q, qr;
  logic guard, sticky, inexact, rnd, tiny, big;
  logic [16:0] enc;
  assign q = (SW+1)'(mag >> lsb);
  assign guard = mag[lsb - 7'd1];
  assign sticky = |(mag & ((ACC_W'(1) << (lsb - 7'd1)) - ACC_W'(1)));
  assign inexact = guard | sticky;
  always_comb begin
    case (rmode)
      2'b00:   rnd = guard & (sticky | q[0]);
      2'b01:   rnd = rsign & inexact;
      2'b10:   rnd = ~rsign & inexact;
      default: rnd = 1'b0;
    endcase
  end
  assign qr = q + {{SW{1'b0}}, rnd};
  assign enc = ({10'b0, lsb - 7'(SUB_LSB)} << FW) + {5'b0, qr};
  assign big = enc >= 17'h7C00;
  assign tiny = lead < 7'(NORM_LEAD);

  logic any_nan, any_snan, zero_inf, pinf, inf_clash, invalid, den;
  assign any_nan = ka[2] | kb[2] | kc[2];
  assign any_snan = ka[3] | kb[3] | kc[3];
  assign zero_inf = (ka[1] & b_zero) | (a_zero & kb[1]);
  assign pinf = (ka[1] | kb[1]) & ~zero_inf & ~ka[2] & ~kb[2];
  assign inf_clash = pinf & kc[1] & (ps ^ cs);
  assign invalid = any_snan | zero_inf | inf_clash;
  assign den = ka[0] | kb[0] | kc[0];

  logic [15:0] nres;
  logic [4:0] nfl;
  logic to_max;
  assign to_max = (rmode == 2'b11) | (rmode == 2'b01 & ~rsign) | (rmode == 2'b10 & rsign);

  always_comb begin
    nres = '0;
    nfl = '0;
    nfl[1] = den;
    if (any_nan | invalid) begin
      nres = 16'h7E00;
      nfl[0] = invalid;
    end else if (pinf) begin
      nres = {ps, 15'h7C00};
    end else if (kc[1]) begin
      nres = {cs, 15'h7C00};
    end else if (mag == '0) begin
      nres = {(ps == cs) ? ps : (rmode == 2'b01), 15'h0000};
    end else if (big) begin
      nres = {rsign, to_max ? 15'h7BFF : 15'h7C00};
      nfl[2] = 1'b1;
      nfl[4] = 1'b1;
    end else begin
      nres = {rsign, enc[14:0]};
      nfl[3] = tiny & inexact;
      nfl[4] = inexact;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result <= '0;
      flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nres;
        flags <= nfl;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7
  invalid_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags[0] |-> result == 16'h7E00);
  // R9
  overflow_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags[2] |-> flags[4] && (result[14:0] == 15'h7C00 || result[14:0] == 15'h7BFF));
  // R10
  underflow_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && flags[3] |-> flags[4] && result[14:10] <= 5'd1);
  // R6
  denormal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_a[14:10] == 5'd0 && op_a[9:0] != 10'd0 |=> flags[1]);
endmodule

// File: tb/hfma16_test.sv
module hfma16_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0, op_c = '0;
  logic negate = 1'b0;
  logic [1:0] rmode = 2'b00;
  logic out_valid;
  logic [15:0] result;
  logic [4:0] flags;

  int tests = 0;
  int fails = 0;
  logic [20:0] exp_q[$];
  logic [50:0] in_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  hfma16 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .negate(negate), .rmode(rmode),
    .out_valid(out_valid), .result(result), .flags(flags)
  );

  function automatic bit is_nan(input logic [15:0] x);
    return (&x[14:10]) && (|x[9:0]);
  endfunction
  function automatic bit is_snan(input logic [15:0] x);
    return is_nan(x) && !x[9];
  endfunction
  function automatic bit is_inf(input logic [15:0] x);
    return (&x[14:10]) && !(|x[9:0]);
  endfunction
  function automatic bit is_zero(input logic [15:0] x);
    return x[14:0] == 15'h0;
  endfunction
  function automatic bit is_sub(input logic [15:0] x);
    return x[14:10] == 5'd0 && x[9:0] != 10'd0;
  endfunction

  // {flags, result}; flags = {inexact, underflow, overflow, denormal, invalid}
  function automatic logic [20:0] ref_fma(input logic [15:0] a, input logic [15:0] b,
                                          input logic [15:0] c, input logic ng, input logic [1:0] rm);
    logic [4:0] fl;
    logic [15:0] r;
    logic ps, rs, inx, up, pinf;
    int ea, eb, ec, ep, emin, m, top, lx, sh, be;
    logic [127:0] pm, cm, mag, q, rem, half;
    logic signed [127:0] s;
    fl = '0;
    r = '0;
    fl[1] = is_sub(a) | is_sub(b) | is_sub(c);
    ps = a[15] ^ b[15] ^ ng;
    pinf = is_inf(a) | is_inf(b);
    if (is_snan(a) || is_snan(b) || is_snan(c) || (is_inf(a) && is_zero(b)) ||
        (is_zero(a) && is_inf(b)) ||
        (pinf && !is_nan(a) && !is_nan(b) && is_inf(c) && ps != c[15])) begin
      fl[0] = 1'b1;
      r = 16'h7E00;
    end else if (is_nan(a) || is_nan(b) || is_nan(c)) begin
      r = 16'h7E00;
    end else if (pinf) begin
      r = {ps, 15'h7C00};
    end else if (is_inf(c)) begin
      r = {c[15], 15'h7C00};
    end else begin
      ea = (a[14:10] == 0) ? -24 : int'(a[14:10]) - 25;
      eb = (b[14:10] == 0) ? -24 : int'(b[14:10]) - 25;
      ec = (c[14:10] == 0) ? -24 : int'(c[14:10]) - 25;
      ep = ea + eb;
      emin = (ep < ec) ? ep : ec;
      pm = (128'({a[14:10] != 0, a[9:0]}) * 128'({b[14:10] != 0, b[9:0]})) << (ep - emin);
      cm = 128'({c[14:10] != 0, c[9:0]}) << (ec - emin);
      s = (ps ? -$signed(pm) : $signed(pm)) + (c[15] ? -$signed(cm) : $signed(cm));
      if (s == 0) begin
        r = {(ps == c[15]) ? ps : (rm == 2'b01), 15'h0};
      end else begin
        rs = s < 0;
        mag = rs ? 128'(-s) : 128'(s);
        m = 0;
        for (int i = 0; i < 128; i++) if (mag[i]) m = i;
        top = m + emin;
        lx = (top - 10 > -24) ? top - 10 : -24;
        sh = lx - emin;
        if (sh <= 0) begin
          q = mag << (-sh);
          rem = '0;
          half = '0;
        end else begin
          q = mag >> sh;
          rem = mag & ((128'(1) << sh) - 1);
          half = 128'(1) << (sh - 1);
        end
        inx = rem != 0;
        case (rm)
          2'b00: up = inx && (rem > half || (rem == half && q[0]));
          2'b01: up = rs && inx;
          2'b10: up = !rs && inx;
          default: up = 1'b0;
        endcase
        q = q + 128'(up);
        if (q == 2048) begin
          q = 1024;
          lx = lx + 1;
        end
        fl[4] = inx;
        fl[3] = inx && (top < -14);
        if (q < 1024) begin
          r = {rs, 5'd0, q[9:0]};
        end else begin
          be = lx + 25;
          if (be >= 31) begin
            fl[2] = 1'b1;
            fl[4] = 1'b1;
            fl[3] = 1'b0;
            if (rm == 2'b11 || (rm == 2'b01 && !rs) || (rm == 2'b10 && rs)) r = {rs, 15'h7BFF};
            else r = {rs, 15'h7C00};
          end else begin
            r = {rs, 5'(be), q[9:0]};
          end
        end
      end
    end
    return {fl, r};
  endfunction

  task automatic send_exp(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                          input logic ng, input logic [1:0] rm, input logic [20:0] expv, input string tag);
    @(negedge clk);
    op_a = a;
    op_b = b;
    op_c = c;
    negate = ng;
    rmode = rm;
    in_valid = 1'b1;
    exp_q.push_back(expv);
    in_q.push_back({a, b, c, ng, rm});
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                      input logic ng, input logic [1:0] rm, input string tag);
    send_exp(a, b, c, ng, rm, ref_fma(a, b, c, ng, rm), tag);
  endtask

  function automatic logic [15:0] pick_op();
    logic [15:0] v;
    logic [15:0] specials [8];
    specials = '{16'h7C00, 16'hFC00, 16'h7E00, 16'h7D00, 16'h0000, 16'h8000, 16'h7BFF, 16'h0400};
    case ($urandom % 8)
      0: v = {1'($urandom), 5'd0, 10'($urandom)};
      1: v = specials[$urandom % 8];
      2, 3: v = {1'($urandom), 5'(13 + $urandom % 5), 10'($urandom)};
      4: v = {1'($urandom), 5'(1 + $urandom % 6), 10'($urandom)};
      default: v = {1'($urandom), 5'($urandom % 31), 10'($urandom)};
    endcase
    return v;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [20:0] e;
      logic [50:0] iv;
      string t;
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected output: got %h/%b expected no output", result, flags);
      end else begin
        e = exp_q.pop_front();
        iv = in_q.pop_front();
        t = tag_q.pop_front();
        if ({flags, result} !== e) begin
          fails++;
          $display("FAIL %s a=%h b=%h c=%h neg=%0d rm=%0d: got %h/%b expected %h/%b",
                   t, iv[50:35], iv[34:19], iv[18:3], iv[2], iv[1:0], result, flags, e[15:0], e[20:16]);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired: got still running, expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || result !== 16'h0 || flags !== 5'h0) begin
      fails++;
      $display("FAIL R2 reset state: got %b/%h/%b expected 0/0000/00000", out_valid, result, flags);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // hand-computed cases
    send_exp(16'h3C00, 16'h3C00, 16'h3C00, 1'b0, 2'b00, {5'b00000, 16'h4000}, "R3 one*one+one");
    send_exp(16'h3C01, 16'h3C01, 16'hBC02, 1'b0, 2'b00, {5'b00000, 16'h0010}, "R3 unrounded product");
    send_exp(16'h3C00, 16'h4000, 16'h4200, 1'b1, 2'b00, {5'b00000, 16'h3C00}, "R4 negated product");
    send_exp(16'h3C00, 16'h3C00, 16'h1000, 1'b0, 2'b00, {5'b10000, 16'h3C00}, "R5 tie to even");
    send_exp(16'h3C00, 16'h3C00, 16'h1000, 1'b0, 2'b10, {5'b10000, 16'h3C01}, "R5 tie upward");
    send_exp(16'h0001, 16'h3C00, 16'h0000, 1'b0, 2'b00, {5'b00010, 16'h0001}, "R6 subnormal exact");
    send_exp(16'h7C00, 16'h0000, 16'h3C00, 1'b0, 2'b00, {5'b00001, 16'h7E00}, "R7 inf times zero");
    send_exp(16'h7C00, 16'h3C00, 16'hFC00, 1'b0, 2'b00, {5'b00001, 16'h7E00}, "R7 inf minus inf");
    send_exp(16'h7D00, 16'h3C00, 16'h3C00, 1'b0, 2'b00, {5'b00001, 16'h7E00}, "R7 signalling NaN");
    send_exp(16'h7E01, 16'h3C00, 16'h3C00, 1'b0, 2'b00, {5'b00000, 16'h7E00}, "R7 quiet NaN");
    send_exp(16'h3C00, 16'h3C00, 16'hBC00, 1'b0, 2'b00, {5'b00000, 16'h0000}, "R8 cancel nearest");
    send_exp(16'h3C00, 16'h3C00, 16'hBC00, 1'b0, 2'b01, {5'b00000, 16'h8000}, "R8 cancel downward");
    send_exp(16'h8000, 16'h3C00, 16'h8000, 1'b0, 2'b10, {5'b00000, 16'h8000}, "R8 same-sign zeros");
    send_exp(16'h7BFF, 16'h4000, 16'h0000, 1'b0, 2'b00, {5'b10100, 16'h7C00}, "R9 overflow to inf");
    send_exp(16'h7BFF, 16'h4000, 16'h0000, 1'b0, 2'b11, {5'b10100, 16'h7BFF}, "R9 overflow to max");
    send_exp(16'h7BFF, 16'hC000, 16'h0000, 1'b0, 2'b10, {5'b10100, 16'hFBFF}, "R9 negative overflow up");
    send_exp(16'h0001, 16'h3800, 16'h0000, 1'b0, 2'b00, {5'b11010, 16'h0000}, "R10 underflow tie");
    send_exp(16'h0001, 16'h3800, 16'h0000, 1'b0, 2'b10, {5'b11010, 16'h0001}, "R10 underflow upward");
    send_exp(16'h7C00, 16'hBC00, 16'h3C00, 1'b0, 2'b00, {5'b00000, 16'hFC00}, "R11 infinite product");
    send_exp(16'h3C00, 16'h0001, 16'hFC00, 1'b0, 2'b00, {5'b00010, 16'hFC00}, "R11 infinite addend");

    // model-checked directed sweeps
    for (int m = 0; m < 4; m++) begin
      send(16'h3C00, 16'h3C00, 16'h1001, 1'b0, 2'(m), "R5 above tie");
      send(16'h3C01, 16'h3C00, 16'h1000, 1'b1, 2'(m), "R5 R4 negative tie");
      send(16'h03FF, 16'h3C00, 16'h0001, 1'b0, 2'(m), "R6 subnormal to normal");
      send(16'h0200, 16'h3BFF, 16'h0000, 1'b0, 2'(m), "R6 R10 subnormal rounding");
      send(16'h3C00, 16'h4000, 16'hC000, 1'b1, 2'(m), "R8 R4 negated sum zero");
      send(16'h5BFF, 16'h5BFF, 16'hFBFF, 1'b0, 2'(m), "R9 near max");
    end

    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a, b, c;
      logic ng;
      logic [1:0] rm;
      a = pick_op();
      b = pick_op();
      ng = 1'($urandom);
      rm = 2'($urandom);
      if (n % 4 == 0) begin
        c = ref_fma(a, b, 16'h0000, ng, 2'b00);
        c = c ^ 16'h8000;
        c[0] = c[0] ^ 1'($urandom);
      end else begin
        c = pick_op();
      end
      send(a, b, c, ng, rm, "R3 random");
    end

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    tests++;
    if (out_valid !== 1'b0 || exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1 idle: got out_valid=%b pending=%0d expected 0/0", out_valid, exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule